// File: doc/BRIEF.md
# VLIW Integer and Branch Slot Allocator

This block takes one instruction packet of up to six operations, each tagged with an operation class. It maps every present operation onto one of four integer issue slots or one of two branch issue slots, honouring each class's slot restrictions. If any operation cannot be placed, the whole packet is marked illegal. An illegal packet reports no slot for any operation. The allocator is combinational. Its only state is a pair of divider occupancy counters, which carry long divide latencies across later packets.

The packet arrives on a valid/ready interface. `pkt_ready_o` goes low (a stall) only when a legal packet holds more divides than there are idle dividers. While stalled, the sender keeps `pkt_valid_i`, `op_valid_i` and `op_class_i` stable until ready returns high. A packet is consumed on a rising clock edge where both valid and ready are high. Ready is worked out from the packet contents, so it may change with the inputs, but valid must never wait on ready. Illegal packets are never stalled. They are consumed like any other packet, dispatch nothing and claim no divider.

Placement is greedy. Operation classes are visited in rounds, from the most constrained class to the least. Within a round, operations are taken in packet order, and each one gets the lowest-numbered free slot it is allowed to use.

Top module: `vliw_slot_alloc`

## Requirements
- R1: Slot codes are 0..3 for integer slots I0..I3, 4 for B0, 5 for B1 and 7 for no slot. Class code 0 (simple integer, including set-high/set-low) may use any integer slot. Simple integer operations are placed last, in packet order, each on the lowest free slot. A fifth integer operation makes the packet illegal.
- R2: Class codes 1 (multiply), 2 (divide) and 3 (load) may use only I0 or I1. Class codes 5 (register transfer) and 6 (jump-and-link) may use only I0. The placement rounds run in this order: codes 5/6, then code 4 (store), then codes 1/2/3, then code 0.
- R3: A packet holding both a load and a store is illegal. At most two loads and at most two stores fit in one packet.
- R4: A store (code 4) takes I0. A store may take I1 only when another store of the same packet holds I0. Otherwise the packet is illegal.
- R5: Class code 7 (branch/jump) and code 8 (condition-register operation) use B0 or B1. Code 9 (call) uses only B0 and is placed before codes 7 and 8. A second call, or a third branch-class operation, makes the packet illegal.
- R6: A present operation with a class code of 10 to 15 makes the packet illegal. Every illegal packet drives `pkt_legal_o` low and shows 7 in every slot field.
- R7: A divide consumed in a packet holds one of two dividers for the 18 cycles after its issue cycle. A legal packet whose divide count exceeds the idle dividers drives `pkt_ready_o` low.
- R8: Packets with no divide, and illegal packets, are never stalled. A packet claims dividers only on a valid-and-ready edge.
- R9: A synchronous reset releases both dividers, so a two-divide packet is ready right after reset.
- R10: An operation whose `op_valid_i` bit is low gets slot code 7 and uses no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pkt_valid_i | input | 1 | Packet present |
| pkt_ready_o | output | 1 | Packet can be consumed this edge (low = stall) |
| op_valid_i | input | 6 | Per-operation present bits |
| op_class_i | input | 24 | Per-operation 4-bit class code, operation i at bits [4i+3:4i] |
| pkt_legal_o | output | 1 | Every present operation found a slot |
| slot_o | output | 18 | Per-operation 3-bit slot code, operation i at bits [3i+2:3i] |

## Verification
The hardest state to reach from the ports is a stall: both dividers must be busy while a legal divide packet is waiting, and the release edge 18 cycles later must then be found exactly. The stimulus gets there in two ways. One is a two-divide packet that fills both dividers on one edge, held through every counted cycle until ready comes back. The other is a pair of single-divide packets that fill the dividers one at a time. While the dividers are full, the bench offers non-divide and illegal divide packets to show that only the legal divide packet is held back. It then issues a reset and confirms that the dividers are free again.

// File: rtl/vsa_pkg.sv
package vsa_pkg;
  localparam int CLS_W  = 4;
  localparam int SLOT_W = 3;
  localparam logic [SLOT_W-1:0] SLOT_NONE = 3'd7;

  typedef enum logic [CLS_W-1:0] {
    OP_INT    = 4'd0,
    OP_MUL    = 4'd1,
    OP_DIV    = 4'd2,
    OP_LOAD   = 4'd3,
    OP_STORE  = 4'd4,
    OP_XFER   = 4'd5,
    OP_JLINK  = 4'd6,
    OP_BRANCH = 4'd7,
    OP_CCR    = 4'd8,
    OP_CALL   = 4'd9
  } op_class_e;

  localparam logic [CLS_W-1:0] LAST_CLASS = OP_CALL;

  function automatic logic is_int_class(input logic [CLS_W-1:0] c);
    return c <= OP_JLINK;
  endfunction

  function automatic logic is_br_class(input logic [CLS_W-1:0] c);
    return (c >= OP_BRANCH) && (c <= OP_CALL);
  endfunction
endpackage

// File: rtl/vsa_int_alloc.sv
module vsa_int_alloc
  import vsa_pkg::*;
#(
  parameter int N_OPS   = 6,
  parameter int N_ISLOT = 4
) (
  input  logic [N_OPS-1:0]        op_valid_i,
  input  logic [N_OPS*CLS_W-1:0]  op_class_i,
  output logic [N_OPS*SLOT_W-1:0] code_o,
  output logic                    ok_o
);
  localparam int N_TIER = 4;

  // Round in which a class is placed: most constrained first.
  function automatic int tier_of(input logic [CLS_W-1:0] c);
    case (c)
      OP_XFER, OP_JLINK:        return 0;
      OP_STORE:                 return 1;
      OP_MUL, OP_DIV, OP_LOAD:  return 2;
      default:                  return 3;
    endcase
  endfunction

  function automatic logic [N_ISLOT-1:0] base_mask(input logic [CLS_W-1:0] c);
    logic [N_ISLOT-1:0] m;
    m = '0;
    case (c)
      OP_XFER, OP_JLINK:       m[0] = 1'b1;
      OP_MUL, OP_DIV, OP_LOAD: begin m[0] = 1'b1; m[1] = 1'b1; end
      OP_INT:                  m = '1;
      default:                 m = '0;
    endcase
    return m;
  endfunction

  always_comb begin
    logic [N_ISLOT-1:0] free;
    logic [N_ISLOT-1:0] cand;
    logic [CLS_W-1:0]   c;
    logic               st_in_i0;
    logic               has_ld;
    logic               has_st;
    logic               placed;
    free     = '1;
    cand     = '0;
    c        = '0;
    st_in_i0 = 1'b0;
    has_ld   = 1'b0;
    has_st   = 1'b0;
    placed   = 1'b0;
    ok_o     = 1'b1;
    code_o   = {N_OPS{SLOT_NONE}};
    for (int t = 0; t < N_TIER; t++) begin
      for (int i = 0; i < N_OPS; i++) begin
        c = op_class_i[i*CLS_W +: CLS_W];
        if (op_valid_i[i] && is_int_class(c) && tier_of(c) == t) begin
          if (c == OP_STORE) begin
            cand    = '0;
            cand[0] = free[0];
            cand[1] = free[1] & st_in_i0;
            has_st  = 1'b1;
          end else begin
            cand = base_mask(c) & free;
          end
          if (c == OP_LOAD) has_ld = 1'b1;
          placed = 1'b0;
          for (int j = 0; j < N_ISLOT; j++) begin
            if (!placed && cand[j]) begin
              placed  = 1'b1;
              free[j] = 1'b0;
              code_o[i*SLOT_W +: SLOT_W] = SLOT_W'(j);
              if (c == OP_STORE && j == 0) st_in_i0 = 1'b1;
            end
          end
          if (!placed) ok_o = 1'b0;
        end
      end
    end
    if (has_ld && has_st) ok_o = 1'b0;
  end
endmodule

// File: rtl/vsa_br_alloc.sv
module vsa_br_alloc
  import vsa_pkg::*;
#(
  parameter int N_OPS   = 6,
  parameter int N_BSLOT = 2,
  parameter int B_BASE  = 4
) (
  input  logic [N_OPS-1:0]        op_valid_i,
  input  logic [N_OPS*CLS_W-1:0]  op_class_i,
  output logic [N_OPS*SLOT_W-1:0] code_o,
  output logic                    ok_o
);
  always_comb begin
    logic [N_BSLOT-1:0] free;
    logic [N_BSLOT-1:0] cand;
    logic [CLS_W-1:0]   c;
    logic               placed;
    free   = '1;
    cand   = '0;
    c      = '0;
    placed = 1'b0;
    ok_o   = 1'b1;
    code_o = {N_OPS{SLOT_NONE}};
    // Round 0: calls (first branch slot only); round 1: branches and CCR ops.
    for (int t = 0; t < 2; t++) begin
      for (int i = 0; i < N_OPS; i++) begin
        c = op_class_i[i*CLS_W +: CLS_W];
        if (op_valid_i[i] && is_br_class(c) && ((c == OP_CALL) == (t == 0))) begin
          if (c == OP_CALL) begin
            cand    = '0;
            cand[0] = free[0];
          end else begin
            cand = free;
          end
          placed = 1'b0;
          for (int j = 0; j < N_BSLOT; j++) begin
            if (!placed && cand[j]) begin
              placed  = 1'b1;
              free[j] = 1'b0;
              code_o[i*SLOT_W +: SLOT_W] = SLOT_W'(B_BASE + j);
            end
          end
          if (!placed) ok_o = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/vsa_div_tracker.sv
module vsa_div_tracker #(
  parameter int N_DIV    = 2,
  parameter int DIV_HOLD = 18,
  parameter int CNT_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             claim_i,
  input  logic [CNT_W-1:0] claim_cnt_i,
  output logic [CNT_W-1:0] free_cnt_o
);
  localparam int CW = $clog2(DIV_HOLD + 1);

  logic [CW-1:0]    cnt   [N_DIV];
  logic [N_DIV-1:0] grant;

  always_comb begin
    logic [CNT_W-1:0] remaining;
    remaining  = claim_cnt_i;
    grant      = '0;
    free_cnt_o = '0;
    for (int d = 0; d < N_DIV; d++) begin
      if (cnt[d] == '0) begin
        free_cnt_o = free_cnt_o + 1'b1;
        if (claim_i && remaining != '0) begin
          grant[d]  = 1'b1;
          remaining = remaining - 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < N_DIV; g++) begin : g_div
    always_ff @(posedge clk_i) begin
      if (rst_i)              cnt[g] <= '0;
      else if (grant[g])      cnt[g] <= CW'(DIV_HOLD);
      else if (cnt[g] != '0)  cnt[g] <= cnt[g] - 1'b1;
    end

    AST_DIV_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
      grant[g] |=> cnt[g] == CW'(DIV_HOLD)); // R7
    AST_DIV_COUNTDOWN: assert property (@(posedge clk_i) disable iff (rst_i)
      (cnt[g] != '0 && !grant[g]) |=> cnt[g] == $past(cnt[g]) - CW'(1)); // R7
    AST_DIV_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt[g] <= CW'(DIV_HOLD)); // R7
  end

  AST_NO_OVERBOOK: assert property (@(posedge clk_i) disable iff (rst_i)
    claim_i |-> $countones(grant) == int'(claim_cnt_i)); // R7
endmodule

// File: rtl/vliw_slot_alloc.sv
module vliw_slot_alloc
  import vsa_pkg::*;
#(
  parameter int N_OPS    = 6,
  parameter int N_ISLOT  = 4,
  parameter int N_BSLOT  = 2,
  parameter int N_DIV    = 2,
  parameter int DIV_HOLD = 18
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    pkt_valid_i,
  output logic                    pkt_ready_o,
  input  logic [N_OPS-1:0]        op_valid_i,
  input  logic [N_OPS*CLS_W-1:0]  op_class_i,
  output logic                    pkt_legal_o,
  output logic [N_OPS*SLOT_W-1:0] slot_o
);
  localparam int CNT_W   = $clog2(N_OPS + 1);
  localparam int N_SLOTS = N_ISLOT + N_BSLOT;

  logic [N_OPS*SLOT_W-1:0] int_code, br_code;
  logic                    int_ok, br_ok, bad_cls;
  logic [CNT_W-1:0]        ndiv, free_cnt;
  logic                    claim;

  vsa_int_alloc #(.N_OPS(N_OPS), .N_ISLOT(N_ISLOT)) u_int (
    .op_valid_i(op_valid_i), .op_class_i(op_class_i),
    .code_o(int_code), .ok_o(int_ok));

  vsa_br_alloc #(.N_OPS(N_OPS), .N_BSLOT(N_BSLOT), .B_BASE(N_ISLOT)) u_br (
    .op_valid_i(op_valid_i), .op_class_i(op_class_i),
    .code_o(br_code), .ok_o(br_ok));

  always_comb begin
    logic [CLS_W-1:0] c;
    c       = '0;
    bad_cls = 1'b0;
    ndiv    = '0;
    for (int i = 0; i < N_OPS; i++) begin
      c = op_class_i[i*CLS_W +: CLS_W];
      if (op_valid_i[i] && c > LAST_CLASS) bad_cls = 1'b1;
      if (op_valid_i[i] && c == OP_DIV)    ndiv = ndiv + 1'b1;
    end
  end

  assign pkt_legal_o = int_ok && br_ok && !bad_cls;

  for (genvar i = 0; i < N_OPS; i++) begin : g_merge
    assign slot_o[i*SLOT_W +: SLOT_W] =
      !pkt_legal_o                               ? SLOT_NONE :
      (int_code[i*SLOT_W +: SLOT_W] != SLOT_NONE) ? int_code[i*SLOT_W +: SLOT_W] :
                                                    br_code[i*SLOT_W +: SLOT_W];
  end

  assign pkt_ready_o = !(pkt_legal_o && (ndiv > free_cnt));
  assign claim       = pkt_valid_i && pkt_ready_o && pkt_legal_o && (ndiv != '0);

  vsa_div_tracker #(.N_DIV(N_DIV), .DIV_HOLD(DIV_HOLD), .CNT_W(CNT_W)) u_div (
    .clk_i(clk_i), .rst_i(rst_i), .claim_i(claim),
    .claim_cnt_i(ndiv), .free_cnt_o(free_cnt));

  // Observation of the output fields for the checks below.
  logic any_ld, any_st, st_i0, st_i1, call_off_b0;
  always_comb begin
    logic [CLS_W-1:0]  c;
    logic [SLOT_W-1:0] s;
    c = '0; s = '0;
    any_ld = 1'b0; any_st = 1'b0; st_i0 = 1'b0; st_i1 = 1'b0; call_off_b0 = 1'b0;
    for (int i = 0; i < N_OPS; i++) begin
      c = op_class_i[i*CLS_W +: CLS_W];
      s = slot_o[i*SLOT_W +: SLOT_W];
      if (op_valid_i[i] && c == OP_LOAD)  any_ld = 1'b1;
      if (op_valid_i[i] && c == OP_STORE) begin
        any_st = 1'b1;
        if (s == SLOT_W'(0)) st_i0 = 1'b1;
        if (s == SLOT_W'(1)) st_i1 = 1'b1;
      end
      if (op_valid_i[i] && c == OP_CALL && s != SLOT_W'(N_ISLOT)) call_off_b0 = 1'b1;
    end
  end

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_uniq
    logic [N_OPS-1:0] hit;
    always_comb begin
      for (int i = 0; i < N_OPS; i++)
        hit[i] = slot_o[i*SLOT_W +: SLOT_W] == SLOT_W'(s);
    end
    AST_SLOT_UNIQUE: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(hit)); // R1
  end

  AST_STORE_PAIR: assert property (@(posedge clk_i) disable iff (rst_i)
    st_i1 |-> st_i0); // R4
  AST_LDST_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
    pkt_legal_o |-> !(any_ld && any_st)); // R3
  AST_CALL_B0: assert property (@(posedge clk_i) disable iff (rst_i)
    pkt_legal_o |-> !call_off_b0); // R5
endmodule

// File: tb/vliw_slot_alloc_tb_top.sv
module vliw_slot_alloc_tb_top;
  localparam int N_OPS = 6;
  localparam int NV    = 14;
  localparam int HOLD  = 18;

  logic        clk = 1'b0;
  logic        rst;
  logic        pkt_valid;
  logic        pkt_ready;
  logic [5:0]  op_valid;
  logic [23:0] op_class;
  logic        pkt_legal;
  logic [17:0] slot;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk; // 4 ns period, 250 MHz

  vliw_slot_alloc dut_i (
    .clk_i(clk), .rst_i(rst), .pkt_valid_i(pkt_valid), .pkt_ready_o(pkt_ready),
    .op_valid_i(op_valid), .op_class_i(op_class),
    .pkt_legal_o(pkt_legal), .slot_o(slot));

  // Class per operation (-1 = absent), expected slot per operation, expected legal.
  localparam int CLS [NV*N_OPS] = '{
     0, 0, 0, 0, 7, 7,     // v0  R1 R5
     0, 1, 5,-1, 9, 8,     // v1  R2 R10
     4, 4, 0,-1,-1, 7,     // v2  R4
     3, 4,-1,-1,-1,-1,     // v3  R3
     5, 4,-1,-1,-1,-1,     // v4  R4
     3, 3, 3,-1,-1,-1,     // v5  R2
     7, 9,-1,-1,-1,-1,     // v6  R5
     9, 9,-1,-1,-1,-1,     // v7  R5
    12,-1,-1,-1,-1,-1,     // v8  R6
     0, 0, 0, 0, 0,-1,     // v9  R1
    -1,-1,-1,-1,-1,-1,     // v10 R10
     6, 0, 3, 0,-1,-1,     // v11 R2
     4, 0, 4,-1,-1,-1,     // v12 R4
     3, 7, 3, 8,-1,-1      // v13 R5
  };
  localparam int EXP [NV*N_OPS] = '{
     0, 1, 2, 3, 4, 5,
     2, 1, 0, 7, 4, 5,
     0, 1, 2, 7, 7, 4,
     7, 7, 7, 7, 7, 7,
     7, 7, 7, 7, 7, 7,
     7, 7, 7, 7, 7, 7,
     5, 4, 7, 7, 7, 7,
     7, 7, 7, 7, 7, 7,
     7, 7, 7, 7, 7, 7,
     7, 7, 7, 7, 7, 7,
     7, 7, 7, 7, 7, 7,
     0, 2, 1, 3, 7, 7,
     0, 2, 1, 7, 7, 7,
     0, 4, 1, 5, 7, 7
  };
  localparam int LEG [NV] = '{1,1,1,0,0,0,1,0,0,0,1,1,1,1};
  string TAG [NV] = '{"R1","R2","R4","R3","R4","R2","R5","R5","R6","R1","R10","R2","R4","R5"};

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic load_pkt(input int c0, input int c1, input int c2,
                          input int c3, input int c4, input int c5);
    int cs [N_OPS];
    cs = '{c0, c1, c2, c3, c4, c5};
    for (int i = 0; i < N_OPS; i++) begin
      op_valid[i]        = cs[i] >= 0;
      op_class[i*4 +: 4] = cs[i] >= 0 ? 4'(cs[i]) : 4'd0;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog run did not finish");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; pkt_valid = 1'b0; op_valid = '0; op_class = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // Reset state: both dividers idle, a two-divide packet is ready (R9).
    load_pkt(2, 2, -1, -1, -1, -1);
    #1;
    chk("R9", "ready after reset", int'(pkt_ready), 1);
    chk("R2", "div slot op0", int'(slot[2:0]), 0);
    chk("R2", "div slot op1", int'(slot[5:3]), 1);

    // Vector table, no handshake (valid low).
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      load_pkt(CLS[v*6], CLS[v*6+1], CLS[v*6+2], CLS[v*6+3], CLS[v*6+4], CLS[v*6+5]);
      #1;
      chk(TAG[v], $sformatf("legal v%0d", v), int'(pkt_legal), LEG[v]);
      for (int i = 0; i < N_OPS; i++)
        chk(TAG[v], $sformatf("slot v%0d op%0d", v, i), int'(slot[i*3 +: 3]), EXP[v*6+i]);
      chk("R8", $sformatf("ready v%0d", v), int'(pkt_ready), 1);
    end

    // R8: divide packet held with valid low claims nothing.
    @(negedge clk);
    load_pkt(2, 2, -1, -1, -1, -1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    #1 chk("R8", "no claim without valid", int'(pkt_ready), 1);

    // R7: two divides issue, then a held divide packet waits 18 cycles.
    pkt_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R7", "stall right after issue", int'(pkt_ready), 0);
    for (int k = 1; k < HOLD; k++) begin
      @(negedge clk);
      chk("R7", $sformatf("stall cycle %0d", k), int'(pkt_ready), 0);
    end
    @(negedge clk);
    chk("R7", "ready after hold", int'(pkt_ready), 1);
    pkt_valid = 1'b0;

    // R7: single divides fill the dividers one at a time.
    load_pkt(2, -1, -1, -1, -1, -1);
    pkt_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R7", "one divider still idle", int'(pkt_ready), 1);
    @(posedge clk);
    @(negedge clk);
    chk("R7", "both dividers busy", int'(pkt_ready), 0);

    // R8: non-divide and illegal divide packets pass while dividers are busy.
    load_pkt(0, 3, -1, -1, -1, -1);
    #1 chk("R8", "non-divide not stalled", int'(pkt_ready), 1);
    load_pkt(2, 3, 4, -1, -1, -1);
    #1;
    chk("R8", "illegal divide not stalled", int'(pkt_ready), 1);
    chk("R3", "illegal divide packet", int'(pkt_legal), 0);
    @(posedge clk);
    @(negedge clk);
    pkt_valid = 1'b0;

    // R9: synchronous reset releases busy dividers.
    load_pkt(2, 2, -1, -1, -1, -1);
    #1 chk("R7", "still busy before reset", int'(pkt_ready), 0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1 chk("R9", "dividers free after reset", int'(pkt_ready), 1);

    summary();
    $finish;
  end
endmodule